// File: doc/BRIEF.md
# Tunneled Buffer Exchange Controller

This controller sits beside a processing core that consumes and produces whole buffers. It sits in a chain of such stages. The input memory and the output memory are each divided into `NREG` regions. Each region carries a full/empty flag, and the regions are used in strict round-robin order. While the core reads one input region, an upstream producer can fill another. While an output region waits for delivery, the core can write the next one.

After configuration and a start command, the controller asks the upstream producer for a buffer by sending a fill request carrying the source address. A region becomes readable when the producer's empty notification arrives. The core is then started with the configured word count and the region index. When the core reports that it has finished reading, the freed region is requested again at once, while processing continues. Core writes are gated by a can-write signal. A finished output region is handed downstream only against a fill request received from the consumer. The transfer is started with the target address, and the controller sends an empty notification once the data has moved.

Top module: `bufx_ctrl`

## Requirements
- R1: After reset every pulse output (`up_fill_req`, `core_start`, `xfer_go`, `dn_empty_ntf`, `proto_err`) and `core_can_write` is low, and no fill request is issued before `cmd_start`.
- R2: One cycle after the cycle in which `cmd_start` is sampled, a single-cycle `up_fill_req` appears with `up_fill_addr` equal to the source address and `up_fill_region` equal to 0.
- R3: `core_start` is a single-cycle pulse issued only when the next input region in order is full. It is issued in the cycle after the empty notification that filled that region (or after the previous core run ends), with `core_in_region` naming the region and `core_words` the configured count.
- R4: A `core_rd_done` frees the region being read. If no fill request is outstanding, a fill request for that region follows one cycle later, while the core is still running.
- R5: Input regions are requested, filled and read, and output regions are written and sent, in the order 0, 1, ..., NREG-1, 0, ...
- R6: An `up_empty_ntf` that arrives with no fill request outstanding raises `proto_err` for one cycle and changes no region flag and no pointer.
- R7: `core_can_write` is high only while the core is running and the current output region is empty.
- R8: `core_wr_done` marks the current output region full. `xfer_go` is issued only when a downstream fill request (credit) is held, one cycle after both conditions are met, and carries the region index in `xfer_region` and the target address in `xfer_addr`.
- R9: `dn_empty_ntf` pulses in the cycle after `xfer_done` is sampled, with `dn_empty_region` equal to the region just sent.
- R10: Configuration writes (`cfg_sel` 0 = source address, 1 = target address, 2 = word count, taken from the low bits of `cfg_wdata`) take effect only before `cmd_start`. Afterwards they are ignored.
- R11: After an empty notification, if the next region in order is empty, a fill request for it is issued one cycle later, even while the core is running on the region just filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration field select |
| cfg_wdata | input | AW | Configuration write data |
| cmd_start | input | 1 | Start command |
| up_fill_req | output | 1 | Fill request pulse to the producer |
| up_fill_addr | output | AW | Producer address carried by the request |
| up_fill_region | output | RW | Input region to be filled |
| up_empty_ntf | input | 1 | Producer reports a region filled |
| proto_err | output | 1 | Unexpected empty notification pulse |
| core_start | output | 1 | Core start pulse |
| core_words | output | CW | Words the core consumes |
| core_in_region | output | RW | Input region the core reads |
| core_rd_done | input | 1 | Core finished reading its input |
| core_can_write | output | 1 | Core may write the output memory |
| core_out_region | output | RW | Output region the core writes |
| core_wr_done | input | 1 | Core finished writing its output |
| dn_fill_req | input | 1 | Consumer asks for a buffer |
| xfer_go | output | 1 | Start moving an output region downstream |
| xfer_region | output | RW | Output region to move |
| xfer_addr | output | AW | Consumer address for the move |
| xfer_done | input | 1 | Move finished |
| dn_empty_ntf | output | 1 | Empty notification pulse to the consumer |
| dn_empty_region | output | RW | Region announced by the notification |

## Verification
The assertions take for granted a well-behaved neighbourhood. The core pulses `core_rd_done` once per run before `core_wr_done`. `xfer_done` comes only after `xfer_go`. No start or configuration strobe arrives during reset. The stimulus keeps to these rules by driving each message as a single-cycle pulse in the order a real chain would produce it. The only deliberate violation is the unrequested empty notification, which exercises the error path.

// File: rtl/bufx_pkg.sv
package bufx_pkg;

  typedef enum logic [1:0] {
    SEL_SRC   = 2'd0,
    SEL_TGT   = 2'd1,
    SEL_WORDS = 2'd2,
    SEL_NONE  = 2'd3
  } cfg_field_e;

  function automatic int reg_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/bufx_cfg.sv
module bufx_cfg
  import bufx_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          cmd_start,
  output logic          active,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] tgt_addr,
  output logic [CW-1:0] words
);

  logic          active_q, active_d;
  logic [AW-1:0] src_q, src_d, tgt_q, tgt_d;
  logic [CW-1:0] words_q, words_d;
  logic          wr_en;
  cfg_field_e    field;

  assign field = cfg_field_e'(cfg_sel);
  assign wr_en = cfg_we && !active_q;

  always_comb begin
    active_d = active_q | cmd_start;
    src_d    = src_q;
    tgt_d    = tgt_q;
    words_d  = words_q;
    if (wr_en) begin
      case (field)
        SEL_SRC:   src_d   = cfg_wdata;
        SEL_TGT:   tgt_d   = cfg_wdata;
        SEL_WORDS: words_d = cfg_wdata[CW-1:0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      src_q    <= '0;
      tgt_q    <= '0;
      words_q  <= '0;
    end else begin
      active_q <= active_d;
      src_q    <= src_d;
      tgt_q    <= tgt_d;
      words_q  <= words_d;
    end
  end

  assign active   = active_q;
  assign src_addr = src_q;
  assign tgt_addr = tgt_q;
  assign words    = words_q;

  // R10
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && cfg_we) |=> ($stable(src_q) && $stable(tgt_q) && $stable(words_q)));

endmodule

// File: rtl/bufx_in_side.sv
module bufx_in_side #(
  parameter int NREG = 3,
  localparam int RW = bufx_pkg::reg_w(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          up_empty_ntf,
  input  logic          core_rd_done,
  output logic          up_fill_req,
  output logic [RW-1:0] up_fill_region,
  output logic          proto_err,
  output logic          in_avail,
  output logic [RW-1:0] rd_region
);

  function automatic logic [RW-1:0] nxt(input logic [RW-1:0] p);
    return (p == RW'(NREG-1)) ? '0 : p + 1'b1;
  endfunction

  logic [NREG-1:0] full_q, full_d;
  logic [RW-1:0]   fptr_q, fptr_d, rptr_q, rptr_d, rreg_q, rreg_d;
  logic            pend_q, pend_d, req_q, req_d, err_q, err_d;

  always_comb begin
    full_d = full_q;
    fptr_d = fptr_q;
    rptr_d = rptr_q;
    rreg_d = rreg_q;
    pend_d = pend_q;
    req_d  = 1'b0;
    err_d  = 1'b0;
    if (up_empty_ntf) begin
      if (pend_q) begin
        full_d[fptr_q] = 1'b1;
        fptr_d         = nxt(fptr_q);
        pend_d         = 1'b0;
      end else begin
        err_d = 1'b1;
      end
    end
    if (core_rd_done && full_q[rptr_q]) begin
      full_d[rptr_q] = 1'b0;
      rptr_d         = nxt(rptr_q);
    end
    if (active && !pend_q && !full_q[fptr_q]) begin
      req_d  = 1'b1;
      pend_d = 1'b1;
      rreg_d = fptr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= '0;
      fptr_q <= '0;
      rptr_q <= '0;
      rreg_q <= '0;
      pend_q <= 1'b0;
      req_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      full_q <= full_d;
      fptr_q <= fptr_d;
      rptr_q <= rptr_d;
      rreg_q <= rreg_d;
      pend_q <= pend_d;
      req_q  <= req_d;
      err_q  <= err_d;
    end
  end

  assign up_fill_req    = req_q;
  assign up_fill_region = rreg_q;
  assign proto_err      = err_q;
  assign in_avail       = full_q[rptr_q];
  assign rd_region      = rptr_q;

  // R11
  fill_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_fill_req |-> !full_q[up_fill_region]);

endmodule

// File: rtl/bufx_core_seq.sv
module bufx_core_seq #(
  parameter int NREG = 3,
  localparam int RW = bufx_pkg::reg_w(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          in_avail,
  input  logic [RW-1:0] rd_region,
  input  logic          out_free,
  input  logic          core_wr_done,
  output logic          core_start,
  output logic [RW-1:0] core_in_region,
  output logic          core_can_write
);

  logic          busy_q, busy_d, start_q, start_d;
  logic [RW-1:0] reg_q, reg_d;

  always_comb begin
    busy_d  = busy_q;
    start_d = 1'b0;
    reg_d   = reg_q;
    if (busy_q && core_wr_done) begin
      busy_d = 1'b0;
    end else if (active && !busy_q && in_avail) begin
      busy_d  = 1'b1;
      start_d = 1'b1;
      reg_d   = rd_region;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      reg_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      start_q <= start_d;
      reg_q   <= reg_d;
    end
  end

  assign core_start     = start_q;
  assign core_in_region = reg_q;
  assign core_can_write = busy_q && out_free;

  // R3
  start_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> $past(in_avail));

endmodule

// File: rtl/bufx_out_side.sv
module bufx_out_side #(
  parameter int NREG = 3,
  localparam int RW  = bufx_pkg::reg_w(NREG),
  localparam int CRW = $clog2(NREG + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          core_wr_done,
  input  logic          dn_fill_req,
  input  logic          xfer_done,
  output logic          out_free,
  output logic [RW-1:0] wr_region,
  output logic          xfer_go,
  output logic [RW-1:0] xfer_region,
  output logic          dn_empty_ntf,
  output logic [RW-1:0] dn_empty_region
);

  function automatic logic [RW-1:0] nxt(input logic [RW-1:0] p);
    return (p == RW'(NREG-1)) ? '0 : p + 1'b1;
  endfunction

  logic [NREG-1:0] full_q, full_d;
  logic [RW-1:0]   wptr_q, wptr_d, sptr_q, sptr_d;
  logic [RW-1:0]   greg_q, greg_d, nreg_q, nreg_d;
  logic [CRW-1:0]  cred_q, cred_d;
  logic            send_q, send_d, go_q, go_d, ntf_q, ntf_d;
  logic            inc, dec;

  always_comb begin
    full_d = full_q;
    wptr_d = wptr_q;
    sptr_d = sptr_q;
    greg_d = greg_q;
    nreg_d = nreg_q;
    send_d = send_q;
    go_d   = 1'b0;
    ntf_d  = 1'b0;
    dec    = 1'b0;
    inc    = dn_fill_req && (cred_q != CRW'(NREG));
    if (core_wr_done && !full_q[wptr_q]) begin
      full_d[wptr_q] = 1'b1;
      wptr_d         = nxt(wptr_q);
    end
    if (!send_q && full_q[sptr_q] && (cred_q != '0)) begin
      go_d   = 1'b1;
      greg_d = sptr_q;
      send_d = 1'b1;
      dec    = 1'b1;
    end
    if (send_q && xfer_done) begin
      full_d[sptr_q] = 1'b0;
      sptr_d         = nxt(sptr_q);
      send_d         = 1'b0;
      ntf_d          = 1'b1;
      nreg_d         = sptr_q;
    end
    case ({inc, dec})
      2'b10:   cred_d = cred_q + 1'b1;
      2'b01:   cred_d = cred_q - 1'b1;
      default: cred_d = cred_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= '0;
      wptr_q <= '0;
      sptr_q <= '0;
      greg_q <= '0;
      nreg_q <= '0;
      cred_q <= '0;
      send_q <= 1'b0;
      go_q   <= 1'b0;
      ntf_q  <= 1'b0;
    end else begin
      full_q <= full_d;
      wptr_q <= wptr_d;
      sptr_q <= sptr_d;
      greg_q <= greg_d;
      nreg_q <= nreg_d;
      cred_q <= cred_d;
      send_q <= send_d;
      go_q   <= go_d;
      ntf_q  <= ntf_d;
    end
  end

  assign out_free        = !full_q[wptr_q];
  assign wr_region       = wptr_q;
  assign xfer_go         = go_q;
  assign xfer_region     = greg_q;
  assign dn_empty_ntf    = ntf_q;
  assign dn_empty_region = nreg_q;

  // R8
  credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_go |-> ($past(cred_q) != '0));

  // R9
  ntf_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_empty_ntf |-> $past(xfer_done));

endmodule

// File: rtl/bufx_ctrl.sv
module bufx_ctrl #(
  parameter int AW   = 16,
  parameter int CW   = 12,
  parameter int NREG = 3,
  localparam int RW  = bufx_pkg::reg_w(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          cmd_start,
  output logic          up_fill_req,
  output logic [AW-1:0] up_fill_addr,
  output logic [RW-1:0] up_fill_region,
  input  logic          up_empty_ntf,
  output logic          proto_err,
  output logic          core_start,
  output logic [CW-1:0] core_words,
  output logic [RW-1:0] core_in_region,
  input  logic          core_rd_done,
  output logic          core_can_write,
  output logic [RW-1:0] core_out_region,
  input  logic          core_wr_done,
  input  logic          dn_fill_req,
  output logic          xfer_go,
  output logic [RW-1:0] xfer_region,
  output logic [AW-1:0] xfer_addr,
  input  logic          xfer_done,
  output logic          dn_empty_ntf,
  output logic [RW-1:0] dn_empty_region
);

  logic [1:0]    rsync_q;
  logic          rst_s_n;
  logic          active, in_avail, out_free;
  logic [RW-1:0] rd_region;
  logic [AW-1:0] src_addr, tgt_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  bufx_cfg #(.AW(AW), .CW(CW)) u_cfg (
    .clk(clk), .rst_n(rst_s_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cmd_start(cmd_start), .active(active),
    .src_addr(src_addr), .tgt_addr(tgt_addr), .words(core_words)
  );

  bufx_in_side #(.NREG(NREG)) u_in (
    .clk(clk), .rst_n(rst_s_n), .active(active), .up_empty_ntf(up_empty_ntf),
    .core_rd_done(core_rd_done), .up_fill_req(up_fill_req),
    .up_fill_region(up_fill_region), .proto_err(proto_err),
    .in_avail(in_avail), .rd_region(rd_region)
  );

  bufx_core_seq #(.NREG(NREG)) u_seq (
    .clk(clk), .rst_n(rst_s_n), .active(active), .in_avail(in_avail),
    .rd_region(rd_region), .out_free(out_free), .core_wr_done(core_wr_done),
    .core_start(core_start), .core_in_region(core_in_region),
    .core_can_write(core_can_write)
  );

  bufx_out_side #(.NREG(NREG)) u_out (
    .clk(clk), .rst_n(rst_s_n), .core_wr_done(core_wr_done),
    .dn_fill_req(dn_fill_req), .xfer_done(xfer_done), .out_free(out_free),
    .wr_region(core_out_region), .xfer_go(xfer_go), .xfer_region(xfer_region),
    .dn_empty_ntf(dn_empty_ntf), .dn_empty_region(dn_empty_region)
  );

  assign up_fill_addr = src_addr;
  assign xfer_addr    = tgt_addr;

endmodule

// File: tb/sim_bufx_ctrl.sv
module sim_bufx_ctrl;

  localparam int AW = 16, CW = 12, NREG = 3, RW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, cmd_start = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic up_empty_ntf = 1'b0, core_rd_done = 1'b0, core_wr_done = 1'b0;
  logic dn_fill_req = 1'b0, xfer_done = 1'b0;
  logic up_fill_req, proto_err, core_start, core_can_write, xfer_go, dn_empty_ntf;
  logic [AW-1:0] up_fill_addr, xfer_addr;
  logic [CW-1:0] core_words;
  logic [RW-1:0] up_fill_region, core_in_region, core_out_region, xfer_region, dn_empty_region;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bufx_ctrl #(.AW(AW), .CW(CW), .NREG(NREG)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cmd_start(cmd_start), .up_fill_req(up_fill_req),
    .up_fill_addr(up_fill_addr), .up_fill_region(up_fill_region),
    .up_empty_ntf(up_empty_ntf), .proto_err(proto_err), .core_start(core_start),
    .core_words(core_words), .core_in_region(core_in_region),
    .core_rd_done(core_rd_done), .core_can_write(core_can_write),
    .core_out_region(core_out_region), .core_wr_done(core_wr_done),
    .dn_fill_req(dn_fill_req), .xfer_go(xfer_go), .xfer_region(xfer_region),
    .xfer_addr(xfer_addr), .xfer_done(xfer_done), .dn_empty_ntf(dn_empty_ntf),
    .dn_empty_region(dn_empty_region)
  );

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [AW-1:0] val);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    step();
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
    // R1 reset state
    chk("R1 fill_req", int'(up_fill_req), 0);
    chk("R1 core_start", int'(core_start), 0);
    chk("R1 can_write", int'(core_can_write), 0);
    chk("R1 xfer_go", int'(xfer_go), 0);
    chk("R1 dn_ntf", int'(dn_empty_ntf), 0);
    chk("R1 proto_err", int'(proto_err), 0);
    repeat (4) step();
    chk("R1 idle no request", int'(up_fill_req), 0);

    cfg_write(2'd0, 16'h1234);
    cfg_write(2'd1, 16'h5678);
    cfg_write(2'd2, 16'd40);
    chk("R10 idle words write", int'(core_words), 40);

    cmd_start = 1'b1; step(); cmd_start = 1'b0;
    chk("R2 not yet", int'(up_fill_req), 0);
    step();
    chk("R2 fill_req", int'(up_fill_req), 1);
    chk("R2 addr", int'(up_fill_addr), 'h1234);
    chk("R2 region", int'(up_fill_region), 0);
    step();
    chk("R2 pulse", int'(up_fill_req), 0);
    chk("R3 no start while empty", int'(core_start), 0);

    for (int k = 0; k < NREG; k++) begin
      up_empty_ntf = 1'b1; step(); up_empty_ntf = 1'b0;
      step();
      if (k < NREG - 1) begin
        chk("R11 next request", int'(up_fill_req), 1);
        chk("R5 request order", int'(up_fill_region), k + 1);
      end else begin
        chk("R5 all full no request", int'(up_fill_req), 0);
      end
      if (k == 0) begin
        chk("R3 core_start", int'(core_start), 1);
        chk("R3 region", int'(core_in_region), 0);
        chk("R3 words", int'(core_words), 40);
      end else begin
        chk("R3 single start", int'(core_start), 0);
      end
    end

    cfg_write(2'd0, 16'hAAAA);
    cfg_write(2'd2, 16'd7);
    chk("R10 words locked", int'(core_words), 40);

    up_empty_ntf = 1'b1; step(); up_empty_ntf = 1'b0;
    chk("R6 proto_err", int'(proto_err), 1);
    step();
    chk("R6 pulse", int'(proto_err), 0);
    chk("R6 no request", int'(up_fill_req), 0);
    chk("R7 can_write running", int'(core_can_write), 1);
    chk("R7 out region", int'(core_out_region), 0);

    core_rd_done = 1'b1; step(); core_rd_done = 1'b0;
    chk("R4 not yet", int'(up_fill_req), 0);
    step();
    chk("R4 early request", int'(up_fill_req), 1);
    chk("R4 region", int'(up_fill_region), 0);
    chk("R10 addr locked", int'(up_fill_addr), 'h1234);
    chk("R4 core still running", int'(core_can_write), 1);

    core_wr_done = 1'b1; step(); core_wr_done = 1'b0;
    chk("R7 can_write after done", int'(core_can_write), 0);
    step();
    chk("R5 next core start", int'(core_start), 1);
    chk("R5 next core region", int'(core_in_region), 1);
    chk("R8 no credit no xfer", int'(xfer_go), 0);

    dn_fill_req = 1'b1; step(); dn_fill_req = 1'b0;
    chk("R8 not yet", int'(xfer_go), 0);
    step();
    chk("R8 xfer_go", int'(xfer_go), 1);
    chk("R8 xfer region", int'(xfer_region), 0);
    chk("R8 xfer addr", int'(xfer_addr), 'h5678);

    xfer_done = 1'b1; step(); xfer_done = 1'b0;
    chk("R9 dn_ntf", int'(dn_empty_ntf), 1);
    chk("R9 region", int'(dn_empty_region), 0);
    step();
    chk("R9 pulse", int'(dn_empty_ntf), 0);

    for (int b = 1; b <= 2 * NREG; b++) begin
      up_empty_ntf = 1'b1; step(); up_empty_ntf = 1'b0;
      chk("R6 valid notification", int'(proto_err), 0);
      step();
      chk("R5 no request while full", int'(up_fill_req), 0);
      chk("R7 can_write", int'(core_can_write), 1);
      chk("R5 write region", int'(core_out_region), b % NREG);
      core_rd_done = 1'b1; step(); core_rd_done = 1'b0;
      step();
      chk("R4 request", int'(up_fill_req), 1);
      chk("R4 request region", int'(up_fill_region), b % NREG);
      core_wr_done = 1'b1; step(); core_wr_done = 1'b0;
      chk("R7 idle core", int'(core_can_write), 0);
      step();
      chk("R3 start", int'(core_start), 1);
      chk("R5 start region", int'(core_in_region), (b + 1) % NREG);
      dn_fill_req = 1'b1; step(); dn_fill_req = 1'b0;
      step();
      chk("R8 go", int'(xfer_go), 1);
      chk("R8 go region", int'(xfer_region), b % NREG);
      xfer_done = 1'b1; step(); xfer_done = 1'b0;
      chk("R9 ntf", int'(dn_empty_ntf), 1);
      chk("R9 ntf region", int'(dn_empty_region), b % NREG);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule